// File: doc/BRIEF.md
# Multi-Queue Bit Rate Meter

This block measures traffic on four packet queues and on their combined sum. Each queue provides a 32-bit cumulative byte count that runs freely, is owned by logic outside this block, and wraps to zero after its maximum. A window length, given in clock cycles and written by software, sets how often the block takes a snapshot of all four counts at once. At each snapshot the block subtracts the previous snapshot from the new one, modulo 2^32, and multiplies the result by eight to get bits. It then publishes one rate per queue and a total, all expressed in bits per window.

The same block serves the receive side or the transmit side, depending on which set of byte counters is wired to it. Sequencing uses a two-state controller. The first window after reset, or after the meter is re-enabled, only records a baseline. Every later window produces a report. All five outputs change together, exactly one cycle after the window closes, and they hold their values at every other time.

Top module: `qrate_meter`

## Requirements
- R1: A synchronous active-high reset clears every rate output to zero. The first window closing after reset captures a baseline and leaves all outputs at zero.
- R2: With a nonzero window length L, snapshots of all four counts are taken at the L-th clock edge after reset is released or the meter is enabled, and at every L-th edge after that.
- R3: The byte delta of each queue is the new snapshot minus the previous snapshot, modulo 2^32. A counter that wraps past zero therefore yields the true byte count.
- R4: Each queue's reported value is its byte delta times eight. When the product does not fit in 32 bits (a delta of 0x20000000 or more), the value is 0xFFFFFFFF.
- R5: The total output is the sum of the four reported per-queue values. It saturates at 0xFFFFFFFF when the sum exceeds 32 bits.
- R6: All five outputs update together at the clock edge following a reporting snapshot edge. They hold their values at every other edge.
- R7: A window length of zero disables the meter: no snapshots are taken and the outputs keep their last values. When a nonzero length is written again, the first window captures a new baseline and does not change the outputs.
- R8: Queue i is read from byte_cnt bits [32i+31:32i] and is reported on rate_q bits [32i+31:32i], for i = 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_len | input | 32 | Window length in cycles; zero disables the meter |
| byte_cnt | input | 128 | Four cumulative byte counts, queue i in bits [32i+31:32i] |
| rate_q | output | 128 | Four per-queue rates in bits per window, queue i in bits [32i+31:32i] |
| rate_total | output | 32 | Saturated sum of the four per-queue rates |

## Verification
The assertions assume two things about the inputs. First, each counter advances by less than 2^32 bytes within one window, because the modulo difference cannot tell a larger advance apart. Second, the window length changes only while the meter is disabled or right after a report, so a shrinking length never cuts a window short. The stimulus follows both rules. It changes every count at most once per window, always by a modest amount or across a single wrap. It switches the window length only during reset, right after an update edge, or between a disable and a re-enable.

// File: rtl/qrate_pkg.sv
package qrate_pkg;

    // bits per byte expressed as a left shift
    localparam int BYTE_SHIFT = 3;

    // controller phase: the first closing window only records a baseline
    typedef enum logic {
        ST_BASE = 1'b0,
        ST_RUN  = 1'b1
    } meter_st_e;

endpackage

// File: rtl/qrate_window.sv
module qrate_window #(
    parameter int WIN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] win_len,
    output logic             close,
    output logic [WIN_W-1:0] wc
);

    logic [WIN_W-1:0] wc_d, wc_q;

    always_comb begin
        close = 1'b0;
        wc_d  = wc_q + 1'b1;
        if (win_len == '0) begin
            wc_d = '0;
        end else if (wc_q >= win_len - 1'b1) begin
            close = 1'b1;
            wc_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wc_q <= '0;
        else     wc_q <= wc_d;
    end

    assign wc = wc_q;

endmodule

// File: rtl/qrate_scale.sv
module qrate_scale
    import qrate_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int RATE_W = 32
) (
    input  logic [CNT_W-1:0]  delta,
    output logic [RATE_W-1:0] rate
);

    localparam int EXT_W = CNT_W + BYTE_SHIFT;

    logic [EXT_W-1:0] wide;

    always_comb begin
        wide = EXT_W'(delta) << BYTE_SHIFT;
        if ((wide >> RATE_W) != '0) rate = '1;
        else                        rate = wide[RATE_W-1:0];
    end

endmodule

// File: rtl/qrate_sum.sv
module qrate_sum #(
    parameter int NUM_Q  = 4,
    parameter int RATE_W = 32
) (
    input  logic [NUM_Q-1:0][RATE_W-1:0] rates,
    output logic [RATE_W-1:0]            total
);

    localparam int ACC_W = RATE_W + $clog2(NUM_Q) + 1;

    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            acc = acc + ACC_W'(rates[i]);
        end
        if ((acc >> RATE_W) != '0) total = '1;
        else                       total = acc[RATE_W-1:0];
    end

endmodule

// File: rtl/qrate_meter.sv
module qrate_meter
    import qrate_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int CNT_W  = 32,
    parameter int WIN_W  = 32,
    parameter int RATE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [WIN_W-1:0]        win_len,
    input  logic [NUM_Q*CNT_W-1:0]  byte_cnt,
    output logic [NUM_Q*RATE_W-1:0] rate_q,
    output logic [RATE_W-1:0]       rate_total
);

    typedef struct packed {
        meter_st_e                    fsm;
        logic                         pub;
        logic [NUM_Q-1:0][CNT_W-1:0]  prev;
        logic [NUM_Q-1:0][CNT_W-1:0]  delta;
        logic [NUM_Q-1:0][RATE_W-1:0] rate;
        logic [RATE_W-1:0]            total;
    } meter_t;

    meter_t st_d, st_q;

    logic                         close_w;
    logic [WIN_W-1:0]             wc_w;
    logic [NUM_Q-1:0][CNT_W-1:0]  cnt_arr;
    logic [NUM_Q-1:0][RATE_W-1:0] scaled_w;
    logic [RATE_W-1:0]            total_w;
    logic                         pub_w;

    qrate_window #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .win_len (win_len),
        .close   (close_w),
        .wc      (wc_w)
    );

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_queue
        assign cnt_arr[gi] = byte_cnt[gi*CNT_W +: CNT_W];

        qrate_scale #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_scale (
            .delta (st_q.delta[gi]),
            .rate  (scaled_w[gi])
        );

        assign rate_q[gi*RATE_W +: RATE_W] = st_q.rate[gi];
    end

    qrate_sum #(.NUM_Q(NUM_Q), .RATE_W(RATE_W)) u_sum (
        .rates (scaled_w),
        .total (total_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pub = 1'b0;
        if (win_len == '0) begin
            st_d.fsm = ST_BASE;
        end else if (close_w) begin
            for (int i = 0; i < NUM_Q; i++) begin
                st_d.prev[i] = cnt_arr[i];
                if (st_q.fsm == ST_RUN) begin
                    st_d.delta[i] = cnt_arr[i] - st_q.prev[i];
                end
            end
            st_d.pub = (st_q.fsm == ST_RUN);
            st_d.fsm = ST_RUN;
        end
        if (st_q.pub) begin
            st_d.rate  = scaled_w;
            st_d.total = total_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rate_total = st_q.total;
    assign pub_w      = st_q.pub;

endmodule

// File: rtl/qrate_meter_chk.sv
module qrate_meter_chk #(
    parameter int NUM_Q  = 4,
    parameter int WIN_W  = 32,
    parameter int RATE_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic [WIN_W-1:0]        win_len,
    input logic [NUM_Q*RATE_W-1:0] rate_q,
    input logic [RATE_W-1:0]       rate_total,
    input logic                    pub,
    input logic                    close,
    input logic [WIN_W-1:0]        wc
);

    // R1: reset leaves all outputs at zero
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (rate_q == '0 && rate_total == '0));

    // R7: a zero window length parks the counter
    assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (win_len == '0) |=> (wc == '0 && !pub));

    // R2: a report is only pending after a window closed
    assert_pub_after_close_R2: assert property (@(posedge clk) disable iff (rst)
        pub |-> $past(close));

    // R6: without a pending report nothing moves
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !pub |=> ($stable(rate_q) && $stable(rate_total)));

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_q
        // R4: values are whole bytes in bits, or saturated
        always @(posedge clk) begin
            if (!rst) begin
                assert_bit_multiple_R4: assert (
                    rate_q[gi*RATE_W +: 3] == 3'b000 ||
                    rate_q[gi*RATE_W +: RATE_W] == '1);
                // R5: the total never falls below a single queue
                assert_total_bound_R5: assert (
                    rate_total >= rate_q[gi*RATE_W +: RATE_W]);
            end
        end
    end

endmodule

bind qrate_meter qrate_meter_chk #(
    .NUM_Q  (NUM_Q),
    .WIN_W  (WIN_W),
    .RATE_W (RATE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .win_len    (win_len),
    .rate_q     (rate_q),
    .rate_total (rate_total),
    .pub        (pub_w),
    .close      (close_w),
    .wc         (wc_w)
);

// File: tb/tb_qrate_meter.sv
module tb_qrate_meter;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [31:0]  win_len = '0;
    logic [127:0] byte_cnt = '0;
    logic [127:0] rate_q;
    logic [31:0]  rate_total;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int L     = 4;

    logic [31:0] prev_b [4];
    logic [31:0] exp_r  [4];
    logic [31:0] exp_t;

    always #10 clk = ~clk;

    qrate_meter dut (
        .clk        (clk),
        .rst        (rst),
        .win_len    (win_len),
        .byte_cnt   (byte_cnt),
        .rate_q     (rate_q),
        .rate_total (rate_total)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 4; i++) check(req, rate_q[i*32 +: 32], exp_r[i]);
        check(req, rate_total, exp_t);
    endtask

    function automatic logic [31:0] scale(input logic [31:0] d);
        logic [34:0] w;
        w = {3'b000, d} << 3;
        return (w[34:32] != 3'b000) ? 32'hFFFF_FFFF : w[31:0];
    endfunction

    task automatic set_cnt(input logic [31:0] c0, c1, c2, c3);
        byte_cnt = {c3, c2, c1, c0};
    endtask

    task automatic baseline_model();
        for (int i = 0; i < 4; i++) prev_b[i] = byte_cnt[i*32 +: 32];
    endtask

    // precondition: one edge past an update (or a baseline) edge
    task automatic win(input string req, input logic [31:0] c0, c1, c2, c3);
        logic [35:0] acc;
        set_cnt(c0, c1, c2, c3);
        step(L - 1);
        check_all("R6 hold before update");
        acc = '0;
        for (int i = 0; i < 4; i++) begin
            exp_r[i] = scale(byte_cnt[i*32 +: 32] - prev_b[i]);
            acc      = acc + 36'(exp_r[i]);
        end
        exp_t = (acc[35:32] != 4'h0) ? 32'hFFFF_FFFF : acc[31:0];
        baseline_model();
        step(1);
        check_all(req);
    endtask

    task automatic do_reset(input int len, input logic [31:0] c0, c1, c2, c3);
        rst     = 1'b1;
        L       = len;
        win_len = 32'(len);
        set_cnt(c0, c1, c2, c3);
        step(2);
        for (int i = 0; i < 4; i++) exp_r[i] = '0;
        exp_t = '0;
        check_all("R1 during reset");
        rst = 1'b0;
        step(len);
        baseline_model();
        check_all("R1 at baseline edge");
        step(1);
        check_all("R1 baseline reports zero");
    endtask

    task automatic t_basic();
        do_reset(4, 32'd1000, 32'd2000, 32'd3000, 32'd4000);
        win("R2 R4 R5 R8 distinct deltas", 32'd1010, 32'd2000, 32'd3255, 32'd5000);
        win("R2 R8 second window", 32'd1011, 32'd2100, 32'd3255, 32'd5003);
    endtask

    task automatic t_wrap();
        do_reset(3, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0);
        win("R3 wrap across zero", 32'h0000_0010, 32'h0, 32'h8000_0004, 32'h0000_0040);
    endtask

    task automatic t_saturate();
        do_reset(3, 32'h0, 32'h0, 32'h0, 32'h0);
        win("R4 per-queue boundary", 32'h1FFF_FFFF, 32'h2000_0000, 32'h0000_0001, 32'h0);
        win("R5 total saturates", 32'h2FFF_FFFF, 32'h3000_0000, 32'h1000_0001, 32'h1000_0000);
    endtask

    task automatic t_disable();
        do_reset(3, 32'd50, 32'd60, 32'd70, 32'd80);
        win("R2 before disable", 32'd51, 32'd62, 32'd73, 32'd84);
        win_len = '0;
        set_cnt(32'd900, 32'd901, 32'd902, 32'd903);
        step(10);
        check_all("R7 disabled holds outputs");
        win_len = 32'd3;
        step(3);
        baseline_model();
        check_all("R7 re-enable baseline edge");
        step(1);
        check_all("R7 re-enable baseline no update");
        win("R7 report after re-enable", 32'd910, 32'd901, 32'd1002, 32'd904);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_basic();
        t_wrap();
        t_saturate();
        t_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule